// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Block

This block is the host-facing register file and interrupt logic of a two-channel serial controller. A host reaches it over an 8-bit data bus with a 4-bit register address and separate read and write strobes. Each channel has a pair of mode registers. A per-channel pointer selects which one a write reaches, and the pointer advances after each write. Each channel also has a command register, a transmit holding register and a three-entry receive FIFO. The host drains the FIFO through the receive holding register at the same address as the transmit holding register. The two channels share a mask register, an interrupt status register, a 16-bit counter preset written one byte at a time, and a pair of output-port set and reset registers.

A channel goes into local loopback when the top two bits of its second mode register hold binary 10. A transmit write then lands in the channel's own receive FIFO and does not go to the transmitter. A single interrupt request output is latched by events: a receive enqueue on a channel whose receive mask bit is set, the counter expiring with its mask bit set, a receive read that leaves bytes behind, or a mask write that finds a transmit-ready condition. Only a write to the mask register clears it. The serial shifters, the baud generator and the counter's count-down sit outside this block and connect through simple strobes.

Address map: 0/8 mode (A/B), 1/9 status, 2/A command, 3/B holding, 4 mask write / interrupt status read, 5 preset upper byte, 6 preset lower byte, D output-port set (a read returns the port), E output-port reset.

Top module: `duart_regs`

## Requirements
- R1: After a synchronous reset, irq, rdata, tx_load_a/b, power_off, op_out and counter_preset are 0. Both FIFOs are empty, the mask and interrupt status are 0, and both mode pointers select mode register 1.
- R2: A mode write stores into the register the channel's pointer selects and then moves the pointer to mode register 2, where it stays. A mode read returns the selected register without moving the pointer. A command write with bits 6:4 = 001 returns the pointer to mode register 1.
- R3: With mode register 2 bits 7:6 = 10, a holding write enqueues the byte into the same channel's FIFO and gives no tx_load. Otherwise the next cycle shows a one-cycle tx_load with tx_data equal to the byte.
- R4: A byte is enqueued only while the full flag is clear. The FIFO holds 3 bytes, and full is set when the write pointer equals the read pointer after a write. A fourth byte is dropped.
- R5: Any receive enqueue sets status bit 0 (receive ready) and the channel's interrupt status bit (bit 1 for A, bit 5 for B). It sets irq if that same mask bit is set.
- R6: A holding read returns the oldest byte and pops it. If bytes remain, irq is set regardless of the mask. If the FIFO is now empty, receive ready (status bit 0), full (status bit 1) and the receive interrupt status bit clear. A holding read of an empty FIFO moves no pointer.
- R7: A mask write clears irq. In the same cycle irq is set again if mask bit 0 is set with transmitter A enabled and txr_a high, or if mask bit 4 is set with transmitter B enabled and txr_b high. Interrupt status bits 0 and 4 show those enabled-and-ready conditions live.
- R8: A write to address 5 replaces only bits 15:8 of counter_preset. A write to address 6 replaces only bits 7:0. Both bytes read back at their addresses.
- R9: A cnt_expire pulse sets interrupt status bit 3. It sets irq only when mask bit 3 is set. A read of the interrupt status clears bit 3.
- R10: Writing address D sets the op_out bits that are 1 in the data, and writing E clears them. A 1 in bit 2 of a set write also raises power_off, which stays high until reset.
- R11: Command bits act per channel: bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter, bit 3 disables it. rx_push enqueues only while the receiver is enabled. The status byte is {3'b0, tx enabled, rx enabled, txr input, full, receive ready}.
- R12: rdata changes only on the clock edge that samples rd_en and shows the addressed register as it stood before that edge's side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_push_a | input | 1 | Channel A received-byte strobe |
| rx_data_a | input | 8 | Channel A received byte |
| rx_push_b | input | 1 | Channel B received-byte strobe |
| rx_data_b | input | 8 | Channel B received byte |
| txr_a | input | 1 | Channel A transmitter ready |
| txr_b | input | 1 | Channel B transmitter ready |
| cnt_expire | input | 1 | Counter expiry pulse |
| tx_load_a | output | 1 | Channel A byte-to-transmit strobe |
| tx_data_a | output | 8 | Channel A byte to transmit |
| tx_load_b | output | 1 | Channel B byte-to-transmit strobe |
| tx_data_b | output | 8 | Channel B byte to transmit |
| counter_preset | output | 16 | Counter preset value |
| op_out | output | 8 | Output port |
| power_off | output | 1 | Sticky power-off request |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench fills a loopback FIFO to exactly three bytes and pushes a fourth. A design that tests full before the pointer advances would store the fourth byte or flag full a byte early. It clears irq with a zero-mask write before each receive read. This shows whether a read that leaves bytes behind raises irq again and whether the read that empties the FIFO stays quiet. A design that always clears the flags on a read would strand the remaining bytes. A read of an empty FIFO followed by a fresh loopback byte catches a read pointer that drifts when there is nothing to read. Mask writes are also made with each transmit condition missing, the half-byte preset writes are checked for clobbering the other half, and the mode pointer is checked for running past register 2.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int DW = 8;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_MODE_A = 4'h0;
  localparam logic [AW-1:0] A_STAT_A = 4'h1;
  localparam logic [AW-1:0] A_CMD_A  = 4'h2;
  localparam logic [AW-1:0] A_HOLD_A = 4'h3;
  localparam logic [AW-1:0] A_MASK   = 4'h4;
  localparam logic [AW-1:0] A_PRE_HI = 4'h5;
  localparam logic [AW-1:0] A_PRE_LO = 4'h6;
  localparam logic [AW-1:0] A_MODE_B = 4'h8;
  localparam logic [AW-1:0] A_STAT_B = 4'h9;
  localparam logic [AW-1:0] A_CMD_B  = 4'hA;
  localparam logic [AW-1:0] A_HOLD_B = 4'hB;
  localparam logic [AW-1:0] A_OP_SET = 4'hD;
  localparam logic [AW-1:0] A_OP_CLR = 4'hE;

  // mask / interrupt status bit positions
  localparam int M_TX_A = 0;
  localparam int M_RX_A = 1;
  localparam int M_CNT  = 3;
  localparam int M_TX_B = 4;
  localparam int M_RX_B = 5;

  localparam int PWR_BIT = 2;
endpackage

// File: rtl/duart_rx_fifo.sv
module duart_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          ready,
  output logic          more
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic          full_q, ready_q, full_n, ready_n;
  logic          push_ok, pop;

  assign push_ok = push && !full_q;
  assign pop     = pop_req && ready_q;

  always_comb begin
    wp_n    = push_ok ? bump(wp_q) : wp_q;
    rp_n    = pop ? bump(rp_q) : rp_q;
    full_n  = full_q;
    ready_n = ready_q;
    if (push_ok) begin
      full_n = (wp_n == rp_n);
    end else if (pop) begin
      full_n = 1'b0;
    end
    if (push) begin
      ready_n = 1'b1;
    end else if (pop && (rp_n == wp_q)) begin
      ready_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      rp_q    <= '0;
      full_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      wp_q    <= wp_n;
      rp_q    <= rp_n;
      full_q  <= full_n;
      ready_q <= ready_n;
    end
  end

  assign head  = mem[rp_q];
  assign full  = full_q;
  assign ready = ready_q;
  assign more  = pop && (push_ok || (rp_n != wp_q));

  a_r4_full_implies_ready: assert property (@(posedge clk) disable iff (rst)
    full_q |-> ready_q);
  a_r4_no_store_when_full: assert property (@(posedge clk) disable iff (rst)
    (full_q && push && !pop) |=> ($stable(wp_q) && full_q));
  a_r6_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !ready_q && !push) |=> $stable(rp_q));
endmodule

// File: rtl/duart_chan.sv
module duart_chan #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_mode,
  input  logic          wr_cmd,
  input  logic          wr_hold,
  input  logic          rd_hold,
  input  logic [DW-1:0] wdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          txr_in,
  output logic [DW-1:0] mode_rd,
  output logic [DW-1:0] status,
  output logic [DW-1:0] head,
  output logic          rx_rdy,
  output logic          rx_evt,
  output logic          more,
  output logic          tx_en,
  output logic          tx_load,
  output logic [DW-1:0] tx_data
);
  logic [DW-1:0] mode_q [2];
  logic          mode_ptr;
  logic          rx_en_q, tx_en_q;
  logic          loop, push;
  logic [DW-1:0] push_data;
  logic          full;

  assign loop      = (mode_q[1][7:6] == 2'b10);
  assign push      = (wr_hold && loop) || (rx_push && rx_en_q);
  assign push_data = (wr_hold && loop) ? wdata : rx_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      mode_ptr  <= 1'b0;
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      tx_load   <= 1'b0;
      tx_data   <= '0;
    end else begin
      tx_load <= wr_hold && !loop;
      if (wr_hold && !loop) tx_data <= wdata;
      if (wr_mode) begin
        mode_q[mode_ptr] <= wdata;
        mode_ptr         <= 1'b1;
      end else if (wr_cmd && (wdata[6:4] == 3'b001)) begin
        mode_ptr <= 1'b0;
      end
      if (wr_cmd) begin
        if (wdata[1])      rx_en_q <= 1'b0;
        else if (wdata[0]) rx_en_q <= 1'b1;
        if (wdata[3])      tx_en_q <= 1'b0;
        else if (wdata[2]) tx_en_q <= 1'b1;
      end
    end
  end

  duart_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .din    (push_data),
    .pop_req(rd_hold),
    .head   (head),
    .full   (full),
    .ready  (rx_rdy),
    .more   (more)
  );

  assign mode_rd = mode_q[mode_ptr];
  assign status  = {3'b000, tx_en_q, rx_en_q, txr_in, full, rx_rdy};
  assign rx_evt  = push;
  assign tx_en   = tx_en_q;

  a_r3_loop_no_tx: assert property (@(posedge clk) disable iff (rst)
    (wr_hold && loop) |=> !tx_load);
  a_r2_ptr_sticks: assert property (@(posedge clk) disable iff (rst)
    (mode_ptr && !wr_cmd) |=> mode_ptr);
  a_r11_rx_gate: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !rx_en_q && !wr_hold && !rx_rdy && !rd_hold) |=> !rx_rdy);
endmodule

// File: rtl/duart_regs.sv
module duart_regs
  import duart_pkg::*;
#(
  parameter int FIFO_DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rx_push_a,
  input  logic [DW-1:0] rx_data_a,
  input  logic          rx_push_b,
  input  logic [DW-1:0] rx_data_b,
  input  logic          txr_a,
  input  logic          txr_b,
  input  logic          cnt_expire,
  output logic          tx_load_a,
  output logic [DW-1:0] tx_data_a,
  output logic          tx_load_b,
  output logic [DW-1:0] tx_data_b,
  output logic [15:0]   counter_preset,
  output logic [DW-1:0] op_out,
  output logic          power_off,
  output logic          irq
);
  localparam int NCH = 2;

  logic [DW-1:0] imr_q, op_q;
  logic [15:0]   pre_q;
  logic          cnt_rdy_q, irq_q, pwr_q;

  logic [NCH-1:0]          ch_wr_mode, ch_wr_cmd, ch_wr_hold, ch_rd_hold;
  logic [NCH-1:0]          ch_push, ch_txr, ch_rdy, ch_evt, ch_more, ch_txen, ch_load;
  logic [NCH-1:0][DW-1:0]  ch_rxd, ch_mode, ch_stat, ch_head, ch_txd;
  logic [NCH-1:0][AW-1:0]  ch_base;

  assign ch_base = {A_MODE_B, A_MODE_A};
  assign ch_push = {rx_push_b, rx_push_a};
  assign ch_rxd  = {rx_data_b, rx_data_a};
  assign ch_txr  = {txr_b, txr_a};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_wr_mode[c] = wr_en && (addr == ch_base[c]);
    assign ch_wr_cmd[c]  = wr_en && (addr == ch_base[c] + 4'd2);
    assign ch_wr_hold[c] = wr_en && (addr == ch_base[c] + 4'd3);
    assign ch_rd_hold[c] = rd_en && (addr == ch_base[c] + 4'd3);

    duart_chan #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .wr_mode(ch_wr_mode[c]),
      .wr_cmd (ch_wr_cmd[c]),
      .wr_hold(ch_wr_hold[c]),
      .rd_hold(ch_rd_hold[c]),
      .wdata  (wdata),
      .rx_push(ch_push[c]),
      .rx_data(ch_rxd[c]),
      .txr_in (ch_txr[c]),
      .mode_rd(ch_mode[c]),
      .status (ch_stat[c]),
      .head   (ch_head[c]),
      .rx_rdy (ch_rdy[c]),
      .rx_evt (ch_evt[c]),
      .more   (ch_more[c]),
      .tx_en  (ch_txen[c]),
      .tx_load(ch_load[c]),
      .tx_data(ch_txd[c])
    );
  end

  assign tx_load_a = ch_load[0];
  assign tx_load_b = ch_load[1];
  assign tx_data_a = ch_txd[0];
  assign tx_data_b = ch_txd[1];

  logic tx_cond_a, tx_cond_b;
  assign tx_cond_a = ch_txen[0] && txr_a;
  assign tx_cond_b = ch_txen[1] && txr_b;

  logic [DW-1:0] isr;
  assign isr = {2'b00, ch_rdy[1], tx_cond_b, cnt_rdy_q, 1'b0, ch_rdy[0], tx_cond_a};

  logic wr_mask, set_ev, irq_n;
  assign wr_mask = wr_en && (addr == A_MASK);
  assign set_ev  = (ch_evt[0] && imr_q[M_RX_A]) || (ch_evt[1] && imr_q[M_RX_B]) ||
                   (cnt_expire && imr_q[M_CNT]) || (|ch_more);

  always_comb begin
    if (wr_mask)
      irq_n = set_ev || (wdata[M_TX_A] && tx_cond_a) || (wdata[M_TX_B] && tx_cond_b);
    else
      irq_n = irq_q || set_ev;
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (addr)
      A_MODE_A: rd_mux = ch_mode[0];
      A_STAT_A: rd_mux = ch_stat[0];
      A_HOLD_A: rd_mux = ch_head[0];
      A_MASK:   rd_mux = isr;
      A_PRE_HI: rd_mux = pre_q[15:8];
      A_PRE_LO: rd_mux = pre_q[7:0];
      A_MODE_B: rd_mux = ch_mode[1];
      A_STAT_B: rd_mux = ch_stat[1];
      A_HOLD_B: rd_mux = ch_head[1];
      A_OP_SET: rd_mux = op_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q     <= '0;
      op_q      <= '0;
      pre_q     <= '0;
      cnt_rdy_q <= 1'b0;
      irq_q     <= 1'b0;
      pwr_q     <= 1'b0;
      rdata     <= '0;
    end else begin
      irq_q <= irq_n;
      if (rd_en) rdata <= rd_mux;
      if (wr_mask) imr_q <= wdata;
      if (wr_en && addr == A_PRE_HI) pre_q[15:8] <= wdata;
      if (wr_en && addr == A_PRE_LO) pre_q[7:0]  <= wdata;
      if (wr_en && addr == A_OP_SET) begin
        op_q <= op_q | wdata;
        if (wdata[PWR_BIT]) pwr_q <= 1'b1;
      end
      if (wr_en && addr == A_OP_CLR) op_q <= op_q & ~wdata;
      if (cnt_expire) cnt_rdy_q <= 1'b1;
      else if (rd_en && addr == A_MASK) cnt_rdy_q <= 1'b0;
    end
  end

  assign counter_preset = pre_q;
  assign op_out         = op_q;
  assign power_off      = pwr_q;
  assign irq            = irq_q;

  a_r10_power_sticky: assert property (@(posedge clk) disable iff (rst)
    power_off |=> power_off);
  a_r9_cnt_sets_status: assert property (@(posedge clk) disable iff (rst)
    cnt_expire |=> cnt_rdy_q);
  a_r5_rx_irq_a: assert property (@(posedge clk) disable iff (rst)
    (ch_evt[0] && imr_q[M_RX_A]) |=> irq);
  a_r7_mask_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_mask && wdata == 8'h00 && !(|ch_more) && !(|ch_evt) && !cnt_expire) |=> !irq);
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_duart_regs.sv
module sim_duart_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_push_a = 1'b0, rx_push_b = 1'b0;
  logic [7:0] rx_data_a = '0, rx_data_b = '0;
  logic       txr_a = 1'b0, txr_b = 1'b0, cnt_expire = 1'b0;
  logic       tx_load_a, tx_load_b, power_off, irq;
  logic [7:0] tx_data_a, tx_data_b, op_out;
  logic [15:0] counter_preset;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  duart_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata),
    .rx_push_a(rx_push_a), .rx_data_a(rx_data_a),
    .rx_push_b(rx_push_b), .rx_data_b(rx_data_b),
    .txr_a(txr_a), .txr_b(txr_b), .cnt_expire(cnt_expire),
    .tx_load_a(tx_load_a), .tx_data_a(tx_data_a),
    .tx_load_b(tx_load_b), .tx_data_b(tx_data_b),
    .counter_preset(counter_preset), .op_out(op_out),
    .power_off(power_off), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 tx_load", {tx_load_a, tx_load_b}, 0);
    chk("R1 power/op", {power_off, op_out}, 0);
    chk("R1 preset", counter_preset, 0);
    rd(4'h4, d); chk("R1 isr", d, 8'h00);
    rd(4'h1, d); chk("R1 status A", d, 8'h00);
  endtask

  task automatic t_mode_ptr();
    logic [7:0] d;
    wr(4'h8, 8'hAA); wr(4'h8, 8'hBB);
    rd(4'h8, d); chk("R2 ptr at mode2", d, 8'hBB);
    wr(4'h8, 8'hCC);
    rd(4'h8, d); chk("R2 ptr stays mode2", d, 8'hCC);
    wr(4'hA, 8'h10);
    rd(4'h8, d); chk("R2 cmd resets ptr", d, 8'hAA);
    wr(4'h8, 8'h11); wr(4'h8, 8'h00);
  endtask

  task automatic t_loopback();
    logic [7:0] d;
    txr_a = 1'b1;
    wr(4'h0, 8'h13); wr(4'h0, 8'h80);
    wr(4'h4, 8'h02);
    chk("R7 no tx irq when tx disabled", irq, 0);
    wr(4'h3, 8'h11);
    chk("R3 loop no tx_load", tx_load_a, 0);
    chk("R5 irq on rx enqueue", irq, 1);
    rd(4'h1, d); chk("R5 status ready", d, 8'h05);
    rd(4'h4, d); chk("R5 isr rx A", d, 8'h02);
    wr(4'h3, 8'h22); wr(4'h3, 8'h33);
    rd(4'h1, d); chk("R4 full at depth", d, 8'h07);
    wr(4'h3, 8'h44);
    wr(4'h4, 8'h00);
    chk("R7 mask write clears irq", irq, 0);
    rd(4'h3, d); chk("R6 oldest byte", d, 8'h11);
    chk("R6 re-raise irq", irq, 1);
    rd(4'h1, d); chk("R6 full cleared", d, 8'h05);
    rd(4'h3, d); chk("R6 second byte", d, 8'h22);
    wr(4'h4, 8'h00);
    rd(4'h3, d); chk("R4 fourth dropped", d, 8'h33);
    chk("R6 no irq when drained", irq, 0);
    rd(4'h1, d); chk("R6 ready cleared", d, 8'h04);
    rd(4'h4, d); chk("R6 isr rx cleared", d, 8'h00);
    rd(4'h3, d);
    rd(4'h1, d); chk("R6 empty read keeps status", d, 8'h04);
    wr(4'h3, 8'h55);
    rd(4'h3, d); chk("R6 empty read no ptr move", d, 8'h55);
  endtask

  task automatic t_tx_irq();
    wr(4'h2, 8'h04);
    wr(4'h4, 8'h01);
    chk("R7 tx A ready irq", irq, 1);
    txr_a = 1'b0;
    wr(4'h4, 8'h01);
    chk("R7 tx A not ready", irq, 0);
    txr_b = 1'b1;
    wr(4'h4, 8'h10);
    chk("R7 tx B disabled", irq, 0);
    wr(4'hA, 8'h04);
    wr(4'h4, 8'h10);
    chk("R7 tx B enabled", irq, 1);
    wr(4'h4, 8'h00);
  endtask

  task automatic t_tx_path();
    wr(4'hB, 8'h5A);
    chk("R3 tx_load B", tx_load_b, 1);
    chk("R3 tx_data B", tx_data_b, 8'h5A);
    @(negedge clk);
    chk("R3 tx_load one cycle", tx_load_b, 0);
  endtask

  task automatic t_ext_rx();
    logic [7:0] d;
    wr(4'h4, 8'h20);
    @(negedge clk); rx_push_b = 1'b1; rx_data_b = 8'h66;
    @(negedge clk); rx_push_b = 1'b0;
    rd(4'h9, d); chk("R11 rx disabled ignores push", d, 8'h14);
    chk("R11 no irq", irq, 0);
    wr(4'hA, 8'h01);
    @(negedge clk); rx_push_b = 1'b1; rx_data_b = 8'h77;
    @(negedge clk); rx_push_b = 1'b0;
    chk("R5 irq rx B", irq, 1);
    rd(4'h9, d); chk("R11 status B", d, 8'h1D);
    rd(4'hB, d); chk("R11 rx byte B", d, 8'h77);
    wr(4'hA, 8'h02);
    wr(4'h4, 8'h00);
  endtask

  task automatic t_counter();
    logic [7:0] d;
    wr(4'h5, 8'h12); wr(4'h6, 8'h34);
    chk("R8 preset", counter_preset, 16'h1234);
    wr(4'h5, 8'hAB);
    chk("R8 upper only", counter_preset, 16'hAB34);
    wr(4'h6, 8'hCD);
    chk("R8 lower only", counter_preset, 16'hABCD);
    rd(4'h5, d); chk("R8 readback", d, 8'hAB);
    txr_b = 1'b0;
    @(negedge clk); cnt_expire = 1'b1;
    @(negedge clk); cnt_expire = 1'b0;
    chk("R9 masked no irq", irq, 0);
    rd(4'h4, d); chk("R9 isr bit3", d, 8'h08);
    rd(4'h4, d); chk("R9 cleared by read", d, 8'h00);
    wr(4'h4, 8'h08);
    @(negedge clk); cnt_expire = 1'b1;
    @(negedge clk); cnt_expire = 1'b0;
    chk("R9 unmasked irq", irq, 1);
    wr(4'h4, 8'h00);
  endtask

  task automatic t_outport();
    logic [7:0] d;
    wr(4'hD, 8'h03);
    chk("R10 set", op_out, 8'h03);
    chk("R10 no power", power_off, 0);
    wr(4'hE, 8'h01);
    chk("R10 reset", op_out, 8'h02);
    wr(4'hD, 8'h04);
    chk("R10 power off", power_off, 1);
    rd(4'hD, d); chk("R12 op read", d, 8'h06);
    @(negedge clk);
    chk("R12 rdata held", rdata, 8'h06);
    wr(4'hE, 8'h04);
    chk("R10 power sticky", {power_off, op_out}, {1'b1, 8'h02});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode_ptr();
    t_loopback();
    t_tx_irq();
    t_tx_path();
    t_ext_rx();
    t_counter();
    t_outport();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule